// File: doc/BRIEF.md
# Execute-in-place flash line cache

This block fronts a serial flash read sequencer and serves a boot or code execution window. It keeps exactly one line of flash contents (1 KB by default), aligned to the line size. Reads that land inside the valid part of the line are answered from the local buffer in one cycle. An instruction fetch that misses discards the held line and refills it with one long read burst starting at the aligned line base. A data read that misses is served by a short direct flash read, and the held line is left alone, so data loads never evict the code being executed.

The window only accepts requests while the execution enable input is high. Writes into the window are refused: they touch neither the flash nor the buffer, they complete with zero data, and they set a sticky error flag. Software clears this flag with a one-cycle clear pulse. The sequencer side is a simple burst port. A select signal is held high with a start address and a byte count, the sequencer issues the command, address and any dummy cycles itself, and it then returns bytes with a valid strobe.

Top module: `xip_line_cache`

## Requirements
- R1: After reset no line is held (base marked all ones), `req_ready_o` is high when enabled, and `seq_cs_o`, `rsp_valid_o` and `err_o` are low; the first read therefore always reaches the flash.
- R2: A read whose address lies between the line base and line base + LINE_BYTES − 4 inclusive is a hit: `rsp_valid_o` is high in the cycle after acceptance and no flash burst is started.
- R3: Response data is little-endian: byte i of the access (address + i) sits in `rsp_data_o[8i+7:8i]` for i below `req_size_i` (1 to 4); the higher bytes are zero.
- R4: A fetch (`req_fetch_i`=1) that misses, with address offset in the line at most LINE_BYTES − 4, drops the held line, reads LINE_BYTES bytes starting at the address with its low log2(LINE_BYTES) bits cleared, records that base, and then answers from the new line.
- R5: A data read (`req_fetch_i`=0) that misses issues one burst at the exact request address with length `req_size_i` and leaves the held line unchanged.
- R6: A fetch whose address offset exceeds LINE_BYTES − 4 is never a hit and never refills; it is served like a data miss, and the held line stays valid.
- R7: `seq_cs_o` rises in the cycle after acceptance, stays high with `seq_addr_o` and `seq_len_o` stable, and falls in the cycle after the byte that completes `seq_len_o`.
- R8: Only one request is in flight: `req_ready_o` is low from the cycle after acceptance until the response cycle ends, which includes the whole refill.
- R9: An accepted write (`req_write_i`=1) starts no burst, leaves the buffer unchanged, returns zero data one cycle later and sets `err_o`.
- R10: `err_o` stays set until a cycle with `err_clr_i` high; a write accepted in that same cycle keeps it set.
- R11: While `exec_en_i` is low, `req_ready_o` is low and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_en_i | input | 1 | Window enable |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | Request is a write (refused) |
| req_fetch_i | input | 1 | 1: instruction fetch, 0: data read |
| req_addr_i | input | ADDR_W | Byte address in the window |
| req_size_i | input | 3 | Access size in bytes, 1 to 4 |
| req_ready_o | output | 1 | Request accepted when high with valid |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_data_o | output | 32 | Response data, little-endian |
| err_o | output | 1 | Sticky refused-write flag |
| err_clr_i | input | 1 | Clears `err_o` |
| seq_cs_o | output | 1 | Burst select held for the whole burst |
| seq_addr_o | output | ADDR_W | Burst start address |
| seq_len_o | output | log2(LINE_BYTES)+1 | Burst length in bytes |
| seq_rvalid_i | input | 1 | Byte valid from sequencer |
| seq_rdata_i | input | 8 | Byte from sequencer |

## Verification
On every cycle the assertions check the request and burst port discipline: ready stays low while a burst is open or while disabled, the burst address and length stay stable, a refill always starts at an aligned base, the response strobe lasts one cycle, and refused writes raise the flag without opening a burst. Which addresses hit, the little-endian byte order, and the fact that data misses and tail fetches leave the held line intact can only be shown by the bench. It sweeps every offset and size of a 64-byte line against an arithmetic flash image and counts bursts at the sequencer port.

// File: rtl/xip_cache_pkg.sv
package xip_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIRECT,
    ST_FILL,
    ST_RESP
  } xip_state_e;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_BUF,
    SRC_DIR
  } xip_src_e;
endpackage

// File: rtl/xip_hit_check.sv
module xip_hit_check #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned LINE_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              vld_i,
  output logic              hit_o,
  output logic              tail_o
);
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
  localparam int unsigned HIT_LIM = LINE_BYTES - 4;

  logic [ADDR_W:0] lim;

  assign lim    = {1'b0, base_i} + (ADDR_W+1)'(HIT_LIM);
  assign hit_o  = vld_i && (addr_i >= base_i) && ({1'b0, addr_i} <= lim);
  // offsets past the last full word never hit, so never refill either
  assign tail_o = addr_i[OFF_W-1:0] > OFF_W'(HIT_LIM);
endmodule

// File: rtl/xip_line_buf.sv
module xip_line_buf #(
  parameter int unsigned LINE_BYTES = 1024,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] widx_i,
  input  logic [7:0]       wdata_i,
  input  logic [OFF_W-1:0] roff_i,
  input  logic [2:0]       rsize_i,
  output logic [31:0]      rdata_o
);
  logic [7:0] mem_q [LINE_BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [OFF_W-1:0] idx;
    assign idx = roff_i + OFF_W'(i);
    assign rdata_o[8*i +: 8] = (3'(i) < rsize_i) ? mem_q[idx] : 8'h00;
  end
endmodule

// File: rtl/xip_burst_ctrl.sv
module xip_burst_ctrl #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              rvalid_i,
  output logic              cs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [LEN_W-1:0]  cnt_o,
  output logic              take_o,
  output logic              last_o
);
  logic              cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;

  assign take_o = cs_q && rvalid_i;
  assign last_o = take_o && (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else if (start_i && !cs_q) begin
      cs_q   <= 1'b1;
      addr_q <= addr_i;
      len_q  <= len_i;
      cnt_q  <= '0;
    end else if (take_o) begin
      cnt_q <= cnt_q + LEN_W'(1);
      if (last_o) cs_q <= 1'b0;
    end
  end

  assign cs_o   = cs_q;
  assign addr_o = addr_q;
  assign len_o  = len_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/xip_line_cache.sv
module xip_line_cache
  import xip_cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned LINE_BYTES = 1024,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LEN_W     = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_en_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_fetch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_data_o,
  output logic              err_o,
  input  logic              err_clr_i,
  output logic              seq_cs_o,
  output logic [ADDR_W-1:0] seq_addr_o,
  output logic [LEN_W-1:0]  seq_len_o,
  input  logic              seq_rvalid_i,
  input  logic [7:0]        seq_rdata_i
);
  xip_state_e        state_q;
  xip_src_e          src_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [ADDR_W-1:0] base_q;
  logic              line_vld_q;
  logic              err_q;
  logic [31:0]       dir_q;

  logic              acc, hit, tail;
  logic              do_fill, do_direct;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] b_addr;
  logic [LEN_W-1:0]  b_len;
  logic [LEN_W-1:0]  b_cnt;
  logic              b_take, b_last;
  logic [31:0]       buf_rdata;

  assign req_ready_o = exec_en_i && (state_q == ST_IDLE);
  assign acc         = req_valid_i && req_ready_o;
  assign aligned     = {req_addr_i[ADDR_W-1:OFF_W], OFF_W'(0)};

  xip_hit_check #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_hit (
    .addr_i (req_addr_i),
    .base_i (base_q),
    .vld_i  (line_vld_q),
    .hit_o  (hit),
    .tail_o (tail)
  );

  assign do_fill   = acc && !req_write_i && !hit && req_fetch_i && !tail;
  assign do_direct = acc && !req_write_i && !hit && !(req_fetch_i && !tail);
  assign b_addr    = do_fill ? aligned : req_addr_i;
  assign b_len     = do_fill ? LEN_W'(LINE_BYTES) : LEN_W'(req_size_i);

  xip_burst_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (do_fill || do_direct),
    .addr_i   (b_addr),
    .len_i    (b_len),
    .rvalid_i (seq_rvalid_i),
    .cs_o     (seq_cs_o),
    .addr_o   (seq_addr_o),
    .len_o    (seq_len_o),
    .cnt_o    (b_cnt),
    .take_o   (b_take),
    .last_o   (b_last)
  );

  xip_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk_i   (clk_i),
    .we_i    ((state_q == ST_FILL) && b_take),
    .widx_i  (b_cnt[OFF_W-1:0]),
    .wdata_i (seq_rdata_i),
    .roff_i  (addr_q[OFF_W-1:0]),
    .rsize_i (size_q),
    .rdata_o (buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      src_q      <= SRC_ZERO;
      addr_q     <= '0;
      size_q     <= '0;
      base_q     <= '1;
      line_vld_q <= 1'b0;
      err_q      <= 1'b0;
      dir_q      <= '0;
    end else begin
      if (acc && req_write_i) err_q <= 1'b1;
      else if (err_clr_i)     err_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (acc) begin
          addr_q <= req_addr_i;
          size_q <= req_size_i;
          dir_q  <= '0;
          if (req_write_i) begin
            src_q   <= SRC_ZERO;
            state_q <= ST_RESP;
          end else if (hit) begin
            src_q   <= SRC_BUF;
            state_q <= ST_RESP;
          end else if (do_fill) begin
            line_vld_q <= 1'b0;
            base_q     <= '1;
            state_q    <= ST_FILL;
          end else begin
            state_q <= ST_DIRECT;
          end
        end
        ST_DIRECT: if (b_take) begin
          dir_q[8*b_cnt[1:0] +: 8] <= seq_rdata_i;
          if (b_last) begin
            src_q   <= SRC_DIR;
            state_q <= ST_RESP;
          end
        end
        ST_FILL: if (b_last) begin
          line_vld_q <= 1'b1;
          base_q     <= {addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
          src_q      <= SRC_BUF;
          state_q    <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = (state_q == ST_RESP);
  assign err_o       = err_q;

  always_comb begin
    rsp_data_o = '0;
    if (state_q == ST_RESP) begin
      unique case (src_q)
        SRC_BUF: rsp_data_o = buf_rdata;
        SRC_DIR: rsp_data_o = dir_q;
        default: rsp_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/xip_line_cache_chk.sv
module xip_line_cache_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned LINE_BYTES = 1024,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LEN_W     = OFF_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_en_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              err_o,
  input logic              err_clr_i,
  input logic              seq_cs_o,
  input logic [ADDR_W-1:0] seq_addr_o,
  input logic [LEN_W-1:0]  seq_len_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  a_r8_no_accept_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_cs_o |-> !req_ready_o);

  a_r8_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !req_ready_o);

  a_r11_disabled_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_en_i |-> !req_ready_o);

  a_r7_burst_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_cs_o |=> !seq_cs_o || ($stable(seq_addr_o) && $stable(seq_len_o)));

  a_r4_fill_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_cs_o && seq_len_o == LEN_W'(LINE_BYTES)) |-> seq_addr_o[OFF_W-1:0] == '0);

  a_r5_direct_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_cs_o && seq_len_o != LEN_W'(LINE_BYTES)) |->
      (seq_len_o >= LEN_W'(1) && seq_len_o <= LEN_W'(4)));

  a_r2_rsp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r9_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_write_i) |=> (err_o && !seq_cs_o && rsp_valid_o));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !(acc && req_write_i)) |=> !err_o);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
endmodule

bind xip_line_cache xip_line_cache_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_en_i   (exec_en_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .err_o       (err_o),
  .err_clr_i   (err_clr_i),
  .seq_cs_o    (seq_cs_o),
  .seq_addr_o  (seq_addr_o),
  .seq_len_o   (seq_len_o)
);

// File: tb/xip_line_cache_tb_top.sv
module xip_line_cache_tb_top;
  localparam int AW   = 12;
  localparam int LB   = 64;
  localparam int LW   = $clog2(LB) + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic exec_en_i = 1'b1;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_fetch_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [2:0] req_size_i = 3'd1;
  logic req_ready_o, rsp_valid_o, err_o;
  logic [31:0] rsp_data_o;
  logic err_clr_i = 1'b0;
  logic seq_cs_o;
  logic [AW-1:0] seq_addr_o;
  logic [LW-1:0] seq_len_o;
  logic seq_rvalid_i;
  logic [7:0] seq_rdata_i;

  always #4 clk_i = ~clk_i;

  xip_line_cache #(.ADDR_W(AW), .LINE_BYTES(LB)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic logic [7:0] fbyte(int a);
    return 8'((a * 13) ^ (a >> 5));
  endfunction

  function automatic logic [31:0] expv(int a, int sz);
    logic [31:0] r = '0;
    for (int i = 0; i < sz; i++) r[8*i +: 8] = fbyte(a + i);
    return r;
  endfunction

  // flash model: one byte every other cycle while selected
  logic m_active, m_gap;
  logic [AW-1:0] m_addr;
  int m_left;
  int n_txn = 0;
  int t_addr = 0, t_len = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_active <= 0; m_gap <= 0; m_addr <= '0; m_left <= 0;
      seq_rvalid_i <= 0; seq_rdata_i <= '0;
    end else if (!seq_cs_o) begin
      m_active <= 0; seq_rvalid_i <= 0;
    end else if (!m_active) begin
      m_active <= 1; m_addr <= seq_addr_o; m_left <= int'(seq_len_o);
      m_gap <= 1; seq_rvalid_i <= 0;
      n_txn <= n_txn + 1; t_addr <= int'(seq_addr_o); t_len <= int'(seq_len_o);
    end else begin
      m_gap <= ~m_gap;
      if (m_left > 0 && !m_gap) begin
        seq_rvalid_i <= 1; seq_rdata_i <= fbyte(int'(m_addr));
        m_addr <= m_addr + 1'b1; m_left <= m_left - 1;
      end else seq_rvalid_i <= 0;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input int a, input int sz, input bit f, input bit w,
                        input bit clr, output logic [31:0] d, output int lat);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_addr_i = AW'(a); req_size_i = 3'(sz); req_fetch_i = f;
    req_write_i = w; err_clr_i = clr; req_valid_i = 1;
    @(negedge clk_i);
    req_valid_i = 0; err_clr_i = 0; req_write_i = 0;
    chk(req_ready_o == 0, "R8 ready low after accept", 32'(req_ready_o), 0);
    lat = 1;
    while (!rsp_valid_o) begin
      if (seq_cs_o && req_ready_o) chk(0, "R8 ready during burst", 1, 0);
      @(negedge clk_i);
      lat++;
    end
    d = rsp_data_o;
  endtask

  task automatic rd(int a, int sz, bit f, string tag, bit exp_hit);
    logic [31:0] d; int lat; int t0;
    t0 = n_txn;
    access(a, sz, f, 0, 0, d, lat);
    chk(d == expv(a, sz), {tag, " R3 data"}, d, expv(a, sz));
    if (exp_hit) begin
      chk(lat == 1, {tag, " R2 hit latency"}, 32'(lat), 1);
      chk(n_txn == t0, {tag, " R2 no burst on hit"}, 32'(n_txn - t0), 0);
    end else
      chk(n_txn == t0 + 1, {tag, " one burst on miss"}, 32'(n_txn - t0), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; int lat; int t0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1, "R1 ready", 32'(req_ready_o), 1);
    chk(seq_cs_o == 0, "R1 cs", 32'(seq_cs_o), 0);
    chk(rsp_valid_o == 0, "R1 rsp", 32'(rsp_valid_o), 0);
    chk(err_o == 0, "R1 err", 32'(err_o), 0);
    rst_ni = 1;

    // R1 R4 first fetch misses and refills the aligned line
    rd('h105, 4, 1, "R1 R4 first fetch", 0);
    chk(t_addr == 'h100, "R4 fill base", 32'(t_addr), 'h100);
    chk(t_len == LB, "R4 fill length", 32'(t_len), LB);

    // R2 R3 sweep every in-range offset and size, fetch and data
    for (int off = 0; off <= LB - 4; off++)
      for (int sz = 1; sz <= 4; sz++)
        for (int f = 0; f < 2; f++)
          rd('h100 + off, sz, f[0], "R2 sweep", 1);

    // R6 tail fetches bypass and leave the line valid
    for (int off = LB - 3; off < LB; off++) begin
      rd('h100 + off, 1, 1, "R6 tail fetch", 0);
      chk(t_addr == 'h100 + off, "R6 tail burst addr", 32'(t_addr), 32'('h100 + off));
      chk(t_len == 1, "R6 tail burst len", 32'(t_len), 1);
    end
    rd('h100, 4, 1, "R6 line kept", 1);

    // R5 data miss is direct and keeps the line
    for (int sz = 1; sz <= 4; sz++) begin
      rd('h302 + sz, sz, 0, "R5 data miss", 0);
      chk(t_addr == 'h302 + sz, "R5 burst addr", 32'(t_addr), 32'('h302 + sz));
      chk(t_len == sz, "R5 burst len", 32'(t_len), 32'(sz));
    end
    rd('h108, 4, 0, "R5 line kept", 1);

    // R9 write refused, R10 sticky flag
    t0 = n_txn;
    access('h104, 4, 0, 1, 0, d, lat);
    chk(d == 0, "R9 write data zero", d, 0);
    chk(lat == 1, "R9 write latency", 32'(lat), 1);
    chk(n_txn == t0, "R9 no burst", 32'(n_txn - t0), 0);
    chk(err_o == 1, "R9 err set", 32'(err_o), 1);
    rd('h104, 4, 1, "R9 buffer unchanged", 1);
    chk(err_o == 1, "R10 err sticky", 32'(err_o), 1);
    @(negedge clk_i); err_clr_i = 1; @(negedge clk_i); err_clr_i = 0;
    chk(err_o == 0, "R10 err cleared", 32'(err_o), 0);
    access('h110, 2, 0, 1, 1, d, lat);
    chk(err_o == 1, "R10 set wins over clear", 32'(err_o), 1);
    @(negedge clk_i); err_clr_i = 1; @(negedge clk_i); err_clr_i = 0;

    // R4 refill of another line, old line discarded
    rd('h7C2, 3, 1, "R4 second fill", 0);
    chk(t_addr == 'h7C0, "R4 second base", 32'(t_addr), 'h7C0);
    chk(t_len == LB, "R4 second length", 32'(t_len), LB);
    for (int off = 0; off <= LB - 4; off += 7) rd('h7C0 + off, 4, 0, "R4 new line hit", 1);
    rd('h120, 2, 0, "R4 old line gone", 0);
    chk(t_len == 2, "R4 old line direct len", 32'(t_len), 2);

    // R11 disabled window
    @(negedge clk_i); exec_en_i = 0;
    @(negedge clk_i);
    chk(req_ready_o == 0, "R11 not ready", 32'(req_ready_o), 0);
    t0 = n_txn;
    req_addr_i = AW'('h7C4); req_size_i = 3'd4; req_fetch_i = 1; req_valid_i = 1;
    repeat (3) begin
      @(negedge clk_i);
      chk(rsp_valid_o == 0, "R11 no response", 32'(rsp_valid_o), 0);
    end
    req_valid_i = 0;
    chk(n_txn == t0, "R11 no burst", 32'(n_txn - t0), 0);
    exec_en_i = 1;
    rd('h7C4, 4, 1, "R11 enabled again", 1);
    chk(seq_cs_o == 0, "R7 cs idle at end", 32'(seq_cs_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule